// File: doc/BRIEF.md
# Gated Timer/Counter Pair

This block holds two 16-bit up-counters, each kept as a low byte and a high byte. They share one mode register and one run/flag register, and both are written over a simple byte-wide write port. A unit advances when it is running. It runs when its software run bit is set and, if its gate bit is set, only while its gate pin is high. A running unit counts either a free-running tick enable or falling edges on its own external count pin. When a unit wraps, it sets an overflow flag. The interrupt controller clears that flag with a one-cycle clear pulse when it takes the interrupt.

Each unit has two count modes: a plain 16-bit count, and an 8-bit count in the low byte that reloads from the high byte when it wraps. A link bit joins the pair into one 32-bit counter. In that case unit 0 supplies the low half and all the run and source controls, and unit 1 supplies the upper half.

Top module: `tmr_pair_top`

## Requirements
- R1: After a synchronous active-low reset, both counters read 0000H, both overflow flags are 0, and all configuration state (mode, run bits, link bit) is 0.
- R2: With its source bit at 0, a running unit increments by one on each clock in which `tick` is high. It holds its value in clocks where `tick` is low.
- R3: With its gate bit at 0, a unit runs whenever its run bit is 1. With its gate bit at 1, it runs only while its run bit is 1 and its `gate_pin` bit is high. With its run bit at 0 it never runs.
- R4: With its source bit at 1, a running unit ignores `tick`. It increments once for each high-to-low change of its `ext_cnt` pin, seen as a 1 followed by a 0 on two successive clock samples. The count changes on the second clock edge after the pin falls. A rising edge, or a pin held low, adds nothing.
- R5: In 16-bit mode (mode bit 1 of the unit's field at 0), an increment from FFFFH gives 0000H and sets the unit's overflow flag.
- R6: In reload mode (mode bit 1 at 1), only the low byte counts. An increment from FFH loads the low byte from the high byte, leaves the high byte unchanged and sets the overflow flag.
- R7: A pulse on `tf_clr[i]` clears flag i. If an overflow of unit i happens in the same cycle, the flag is set instead.
- R8: Register map on `wr_addr`: 0 is the mode register, with unit 1's field in bits 7:4 and unit 0's field in bits 3:0. Each field is {gate, source, mode1, mode0}. 1 is the control register: bit 7 flag 1, bit 6 run 1, bit 5 flag 0, bit 4 run 0, bits 3:0 unused here. 2 and 3 are unit 0's low and high bytes, 4 and 5 are unit 1's low and high bytes, and bit 0 at address 6 is the link bit.
- R9: With the link bit set, {`cnt1`,`cnt0`} is one 32-bit counter, run and sourced by unit 0's controls, always in plain binary mode. Unit 1's own run bit and mode bits have no effect. Flag 1 is set when the 32-bit count wraps, and the unit 0 wrap never sets flag 0.
- R10: A write to a counter byte wins over an increment of that unit in the same cycle. The written byte takes the data, the other byte keeps its value, and no overflow is flagged.
- R11: A write to the control register loads both overflow flags from bits 7 and 5, unless R7's set or clear applies in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Internal count enable for units in timer source |
| ext_cnt | input | 2 | External count pins, bit i for unit i |
| gate_pin | input | 2 | Gate pins, bit i for unit i |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | BYTE_W | Register write data |
| tf_clr | input | 2 | Flag clear pulses from the interrupt controller |
| cnt0 | output | 2*BYTE_W | Unit 0 count {high, low} |
| cnt1 | output | 2*BYTE_W | Unit 1 count {high, low} |
| tf | output | 2 | Overflow flags, bit i for unit i |

## Verification
The assertions assume that `gate_pin`, `ext_cnt`, `tick` and the write port are synchronous to `clk` and change away from its rising edge. They also assume that reset is held low for at least two clocks, so that the edge samplers start from a known state. The bench drives every input on the falling edge. It holds reset for several cycles, and it lets an external pin stay low for more than one clock, so each fall is seen on two successive samples. Simultaneous events, such as a write with an increment or a clear pulse with an overflow, are set up on one falling edge, so both act on the same rising edge.

// File: rtl/tmr_pkg.sv
// Shared types and register addresses for the gated timer/counter pair.
// Assumes an 8-bit mode register split into two 4-bit unit fields.
package tmr_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
    localparam logic [ADDR_W-1:0] A_C0L  = 3'd2;
    localparam logic [ADDR_W-1:0] A_C0H  = 3'd3;
    localparam logic [ADDR_W-1:0] A_C1L  = 3'd4;
    localparam logic [ADDR_W-1:0] A_C1H  = 3'd5;
    localparam logic [ADDR_W-1:0] A_LINK = 3'd6;

    // One unit's configuration field, MSB first.
    typedef struct packed {
        logic gate;
        logic src;
        logic m1;
        logic m0;
    } tmr_cfg_t;
endpackage

// File: rtl/tmr_fall_det.sv
// Detects a high-to-low change on an external count pin.
// Fires for one cycle when the older of two successive samples is 1
// and the newer one is 0. Assumes the pin is synchronous to clk.
module tmr_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);
    logic [1:0] smp_q;

    // Shift register holding the last two samples of the pin.
    always_ff @(posedge clk) begin
        if (!rst_n) smp_q <= 2'b00;
        else        smp_q <= {smp_q[0], pin};
    end

    assign fall = smp_q[1] & ~smp_q[0];

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall); // R4
endmodule

// File: rtl/tmr_unit.sv
// One counter unit: a low byte and a high byte with two count modes.
// In plain mode the bytes form one binary counter. In reload mode the
// low byte counts and reloads from the high byte when it wraps.
// A byte write in a cycle blocks that cycle's increment and overflow.
module tmr_unit #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                inc,
    input  logic                reload_mode,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [BYTE_W-1:0]   wr_data,
    output logic [2*BYTE_W-1:0] value,
    output logic                ovf
);
    localparam int W2 = 2 * BYTE_W;

    logic [BYTE_W-1:0] lo_q, hi_q;
    logic lo_full, all_full, wr_any;

    assign lo_full  = &lo_q;
    assign all_full = lo_full & (&hi_q);
    assign wr_any   = wr_lo | wr_hi;
    assign value    = {hi_q, lo_q};
    assign ovf      = inc & ~wr_any & (reload_mode ? lo_full : all_full);

    // Byte registers: software writes first, then the mode-selected step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (wr_any) begin
            if (wr_lo) lo_q <= wr_data;
            if (wr_hi) hi_q <= wr_data;
        end else if (inc) begin
            if (reload_mode)
                lo_q <= lo_full ? hi_q : lo_q + BYTE_W'(1);
            else
                {hi_q, lo_q} <= {hi_q, lo_q} + W2'(1);
        end
    end

    AST_STEP_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !reload_mode && !wr_any) |=> value == $past(value) + W2'(1)); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !wr_any) |=> $stable(value)); // R2
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && reload_mode && lo_full && !wr_any) |=> (lo_q == $past(hi_q)) && $stable(hi_q)); // R6
    AST_WR_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !wr_hi) |=> (lo_q == $past(wr_data)) && $stable(hi_q)); // R10
endmodule

// File: rtl/tmr_pair_top.sv
// Two gated timer/counter units with shared mode and control registers.
// Assumes all inputs are synchronous to clk and BYTE_W is at least 8.
// Flag priority per unit: overflow set, then clear pulse, then write.
module tmr_pair_top
    import tmr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [1:0]          ext_cnt,
    input  logic [1:0]          gate_pin,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic [1:0]          tf_clr,
    output logic [2*BYTE_W-1:0] cnt0,
    output logic [2*BYTE_W-1:0] cnt1,
    output logic [1:0]          tf
);
    localparam int NUNITS = 2;

    tmr_cfg_t    cfg_q [NUNITS];
    logic [1:0]  run_bit_q;
    logic        link_q;
    logic [1:0]  tf_q;
    logic [1:0]  evt;
    logic [1:0]  own_inc;
    logic [1:0]  set_w;
    logic        wr_ctrl;
    logic        inc_u0, inc_u1, ovf_u0, ovf_u1;

    assign wr_ctrl = wr_en && (wr_addr == A_CTRL);

    // Configuration registers: mode fields, run bits and the link bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q[0]  <= '0;
            cfg_q[1]  <= '0;
            run_bit_q <= '0;
            link_q    <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                A_MODE: begin
                    cfg_q[1] <= tmr_cfg_t'(wr_data[7:4]);
                    cfg_q[0] <= tmr_cfg_t'(wr_data[3:0]);
                end
                A_CTRL: run_bit_q <= {wr_data[6], wr_data[4]};
                A_LINK: link_q    <= wr_data[0];
                default: ;
            endcase
        end
    end

    // Per-unit event detection, run qualification and overflow flag.
    for (genvar i = 0; i < NUNITS; i++) begin : g_unit_ctl
        logic run_w;

        tmr_fall_det u_fall (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (ext_cnt[i]),
            .fall  (evt[i])
        );

        assign run_w      = run_bit_q[i] & (~cfg_q[i].gate | gate_pin[i]);
        assign own_inc[i] = run_w & (cfg_q[i].src ? evt[i] : tick);

        // Overflow flag: hardware set beats clear pulse beats software write.
        always_ff @(posedge clk) begin
            if (!rst_n)          tf_q[i] <= 1'b0;
            else if (set_w[i])   tf_q[i] <= 1'b1;
            else if (tf_clr[i])  tf_q[i] <= 1'b0;
            else if (wr_ctrl)    tf_q[i] <= wr_data[5 + 2*i];
        end
    end

    assign inc_u0 = own_inc[0];
    assign inc_u1 = link_q ? ovf_u0 : own_inc[1];

    tmr_unit #(.BYTE_W(BYTE_W)) u_unit0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .inc         (inc_u0),
        .reload_mode (cfg_q[0].m1 & ~link_q),
        .wr_lo       (wr_en && (wr_addr == A_C0L)),
        .wr_hi       (wr_en && (wr_addr == A_C0H)),
        .wr_data     (wr_data),
        .value       (cnt0),
        .ovf         (ovf_u0)
    );

    tmr_unit #(.BYTE_W(BYTE_W)) u_unit1 (
        .clk         (clk),
        .rst_n       (rst_n),
        .inc         (inc_u1),
        .reload_mode (cfg_q[1].m1 & ~link_q),
        .wr_lo       (wr_en && (wr_addr == A_C1L)),
        .wr_hi       (wr_en && (wr_addr == A_C1H)),
        .wr_data     (wr_data),
        .value       (cnt1),
        .ovf         (ovf_u1)
    );

    assign set_w = {ovf_u1, ovf_u0 & ~link_q};
    assign tf    = tf_q;

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_u0 && !link_q) |=> tf[0]); // R5
    AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (tf_clr[0] && !set_w[0]) |=> !tf[0]); // R7
    AST_GATE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_q && cfg_q[0].gate && !gate_pin[0] && !wr_en) |=> $stable(cnt0)); // R3
    AST_LINK_NO_TF0: assert property (@(posedge clk) disable iff (!rst_n)
        (link_q && !tf[0] && !wr_en) |=> !tf[0]); // R9
    AST_LINK_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (link_q && ovf_u0 && !wr_en) |=> cnt1 == $past(cnt1) + (2*BYTE_W)'(1)); // R9
endmodule

// File: tb/sim_tmr_pair_top.sv
// Directed bench for the gated timer/counter pair.
module sim_tmr_pair_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [1:0]  ext_cnt = 2'b11;
    logic [1:0]  gate_pin = 2'b00;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  tf_clr = 2'b00;
    logic [15:0] cnt0, cnt1;
    logic [1:0]  tf;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tmr_pair_top u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ext_cnt(ext_cnt),
        .gate_pin(gate_pin), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tf_clr(tf_clr), .cnt0(cnt0), .cnt1(cnt1), .tf(tf)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic ext_fall0();
        @(negedge clk) ext_cnt[0] = 1'b0;
        repeat (3) @(negedge clk);
        ext_cnt[0] = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic clr_pulse(input logic [1:0] m);
        @(negedge clk) tf_clr = m;
        @(negedge clk) tf_clr = 2'b00;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 cnt0", cnt0, 0);
        chk("R1 cnt1", cnt1, 0);
        chk("R1 tf", tf, 0);
        ticks(3);
        chk("R1 stopped after reset", cnt0, 0);
    endtask

    task automatic t_timer();
        wr(3'd2, 8'h10); wr(3'd3, 8'h00);
        chk("R8 low byte address", cnt0, 16'h0010);
        wr(3'd1, 8'h10);
        repeat (5) @(negedge clk);
        chk("R2 hold without tick", cnt0, 16'h0010);
        ticks(7);
        chk("R2 count ticks", cnt0, 16'h0017);
        chk("R8 unit1 run bit separate", cnt1, 0);
    endtask

    task automatic t_gate();
        wr(3'd0, 8'h08);
        gate_pin = 2'b00;
        ticks(5);
        chk("R3 gated low", cnt0, 16'h0017);
        gate_pin = 2'b01;
        ticks(3);
        chk("R3 gated high", cnt0, 16'h001A);
        wr(3'd0, 8'h00);
        gate_pin = 2'b00;
        ticks(4);
        chk("R3 gate bit clear", cnt0, 16'h001E);
        wr(3'd1, 8'h00);
        ticks(3);
        chk("R3 run bit clear", cnt0, 16'h001E);
    endtask

    task automatic t_events();
        wr(3'd0, 8'h04); wr(3'd1, 8'h10);
        ticks(5);
        chk("R4 tick ignored", cnt0, 16'h001E);
        @(negedge clk) ext_cnt[0] = 1'b0;
        @(negedge clk);
        chk("R4 not yet after one edge", cnt0, 16'h001E);
        @(negedge clk);
        chk("R4 counted on second edge", cnt0, 16'h001F);
        @(negedge clk) ext_cnt[0] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R4 rise adds nothing", cnt0, 16'h001F);
        ext_fall0(); ext_fall0();
        chk("R4 three falls", cnt0, 16'h0021);
    endtask

    task automatic t_wrap16();
        wr(3'd1, 8'h00); wr(3'd0, 8'h00);
        wr(3'd3, 8'hFF); wr(3'd2, 8'hFE); wr(3'd1, 8'h10);
        ticks(1);
        chk("R5 FFFF no flag", {cnt0, 14'd0, tf}, {16'hFFFF, 16'h0000});
        ticks(1);
        chk("R5 wrap value", cnt0, 16'h0000);
        chk("R5 flag set", tf, 2'b01);
        clr_pulse(2'b01);
        chk("R7 clear pulse", tf, 2'b00);
        wr(3'd1, 8'h00); wr(3'd3, 8'hFF); wr(3'd2, 8'hFF); wr(3'd1, 8'h10);
        @(negedge clk) begin tick = 1'b1; tf_clr = 2'b01; end
        @(negedge clk) begin tick = 1'b0; tf_clr = 2'b00; end
        chk("R7 set beats clear", tf, 2'b01);
        clr_pulse(2'b01);
    endtask

    task automatic t_ctrl_flags();
        wr(3'd1, 8'hA0);
        chk("R11 flags written", tf, 2'b11);
        wr(3'd1, 8'h00);
        chk("R11 flags cleared", tf, 2'b00);
    endtask

    task automatic t_reload();
        wr(3'd0, 8'h02); wr(3'd3, 8'hF0); wr(3'd2, 8'hFD); wr(3'd1, 8'h10);
        ticks(3);
        chk("R6 reloaded", cnt0, 16'hF0F0);
        chk("R6 flag", tf, 2'b01);
        ticks(2);
        chk("R6 continues", cnt0, 16'hF0F2);
        clr_pulse(2'b01);
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h20); wr(3'd5, 8'h80); wr(3'd4, 8'hFF); wr(3'd1, 8'h40);
        ticks(1);
        chk("R8 unit1 field reload", cnt1, 16'h8080);
        chk("R8 unit1 flag bit", tf, 2'b10);
        chk("R8 unit0 idle", cnt0, 16'hF0F2);
        clr_pulse(2'b10);
        chk("R7 clear unit1", tf, 2'b00);
    endtask

    task automatic t_write_wins();
        wr(3'd1, 8'h00); wr(3'd0, 8'h00);
        wr(3'd3, 8'hFF); wr(3'd2, 8'hFF); wr(3'd1, 8'h10);
        @(negedge clk) begin tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h10; end
        @(negedge clk) begin tick = 1'b0; wr_en = 1'b0; end
        chk("R10 write beats step", cnt0, 16'hFF10);
        chk("R10 no flag", tf, 2'b00);
    endtask

    task automatic t_link();
        wr(3'd1, 8'h00); wr(3'd6, 8'h01); wr(3'd0, 8'h22);
        wr(3'd3, 8'hFF); wr(3'd2, 8'hFE); wr(3'd5, 8'h00); wr(3'd4, 8'h00);
        wr(3'd1, 8'h10);
        ticks(3);
        chk("R9 low half", cnt0, 16'h0001);
        chk("R9 carry into high", cnt1, 16'h0001);
        chk("R9 no flag on half wrap", tf, 2'b00);
        wr(3'd1, 8'h00);
        wr(3'd5, 8'hFF); wr(3'd4, 8'hFF); wr(3'd3, 8'hFF); wr(3'd2, 8'hFF);
        wr(3'd1, 8'h10);
        ticks(1);
        chk("R9 32-bit wrap", {cnt1, cnt0}, 32'h0);
        chk("R9 flag1 only", tf, 2'b10);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_timer();
        t_gate();
        t_events();
        t_wrap16();
        t_ctrl_flags();
        t_reload();
        t_write_wins();
        t_link();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule